// File: doc/BRIEF.md
# Double-Pumped Shared Instruction/Data Memory

This block lets one single-ported word memory serve both the fetch path and the load/store path of a processor in every processor cycle. It runs on a fast clock at twice the processor rate. A slot flop splits each processor cycle into two fast cycles. In the first, the instruction slot, the word at the fetch address is read into the instruction register. In the second, the data slot, the word at the data address is either read into the read-data register or overwritten with the write data, as the write enable selects. By the end of the processor cycle both registered outputs hold their results. The memory is built from two half-width banks, one per 16-bit half of each 32-bit word.

The processor clock is taken to be the fast clock divided by two and phase-aligned with it, so that each processor rising edge falls on an instruction-slot edge. The `slot_data` output shows which slot the next fast edge serves. The processor holds its address, write enable and write data steady for both fast cycles of its cycle.

Top module: `dpmem_shared`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk_fast`, `instr_out` and `rdata_out` become 0 and `slot_data` becomes 0 (instruction slot next). Memory contents are not reset.
- R2: Out of reset, `slot_data` alternates 0, 1, 0, 1, ... on successive rising edges of `clk_fast`. A value of 0 means the coming edge is the instruction slot, and 1 means it is the data slot.
- R3: At an instruction-slot edge, `instr_out` loads the 32-bit word stored at `fetch_addr`.
- R4: At a data-slot edge, `instr_out` does not change.
- R5: At a data-slot edge with `data_we` low, `rdata_out` loads the word stored at `data_addr`. At an instruction-slot edge, `rdata_out` does not change.
- R6: At a data-slot edge with `data_we` high, `data_wdata` is stored at `data_addr` and `rdata_out` keeps its previous value.
- R7: A fetch and a write to the same address in one processor cycle return the old contents on `instr_out`. The next fetch of that address returns the new word.
- R8: `data_we` is sampled only at data-slot edges. If it is high during an instruction-slot edge and low at the following data-slot edge, nothing is written and a read takes place.
- R9: Bits 31:16 of a word are kept in the upper bank and bits 15:0 in the lower bank. Reads rebuild the word as {upper, lower}, so each half reads back at its own bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Memory clock, twice the processor rate |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_addr | input | ADDR_W (6) | Word address for the instruction slot |
| data_addr | input | ADDR_W (6) | Word address for the data slot |
| data_we | input | 1 | Write enable, used in the data slot only |
| data_wdata | input | 32 | Word to store in the data slot |
| instr_out | output | 32 | Registered fetched instruction |
| rdata_out | output | 32 | Registered data read result |
| slot_data | output | 1 | 1 when the next fast edge is the data slot |

## Verification
The hardest case to reach from the ports is a single processor cycle in which the fetch and the write hit the same address. It is the only case in which the order of the two slots can be seen. A directed step sets both addresses equal with the write enable high and expects the old word on the instruction output, then fetches again and expects the new word. The other hard case is a write enable that is high only during the instruction slot. The bench raises it before the first fast edge, drops it between the two edges, and expects a plain read in the data slot. The random phase draws equal addresses often enough to hit overlapping fetch, read and write many more times.

// File: rtl/dpmem_pkg.sv
// Package: shared types for the double-pumped shared memory.
// Assumes: one slot bit is enough because every processor cycle
// holds exactly two fast cycles.
package dpmem_pkg;
    typedef enum logic {
        SLOT_INSTR = 1'b0,
        SLOT_DATA  = 1'b1
    } slot_e;
endpackage

// File: rtl/dpmem_slot_ctrl.sv
// Module: slot flop that splits each processor cycle into an
// instruction slot followed by a data slot.
// Assumes: the fast clock is twice the processor clock and the
// processor edge falls on an instruction-slot edge after reset.
module dpmem_slot_ctrl
    import dpmem_pkg::*;
(
    input  logic  clk_fast,
    input  logic  rst_n,
    output slot_e slot
);
    // Toggle the slot on every fast edge; reset to the instruction slot.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) slot <= SLOT_INSTR;
        else        slot <= (slot == SLOT_INSTR) ? SLOT_DATA : SLOT_INSTR;
    end
endmodule

// File: rtl/dpmem_bank.sv
// Module: one half-width bank of the shared memory, behavioural model.
// Assumes: write is synchronous, read is combinational, and contents
// are undefined until first written.
module dpmem_bank #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk_fast,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Store the write data at the shared address when enabled.
    always_ff @(posedge clk_fast) begin
        if (wr_en) cells[addr] <= wr_data;
    end

    // Present the addressed cell for capture at the next edge.
    always_comb rd_data = cells[addr];
endmodule

// File: rtl/dpmem_capture.sv
// Module: output registers for the fetched instruction and the read data.
// Assumes: rd_word is the word at the address muxed in for the current slot.
module dpmem_capture
    import dpmem_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  slot_e             slot,
    input  logic              wr_req,
    input  logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] instr_q,
    output logic [WORD_W-1:0] rdata_q
);
    // Latch the instruction at the end of the instruction slot only.
    always_ff @(posedge clk_fast) begin
        if (!rst_n)                  instr_q <= '0;
        else if (slot == SLOT_INSTR) instr_q <= rd_word;
    end

    // Latch read data at the end of a data slot that does not write.
    always_ff @(posedge clk_fast) begin
        if (!rst_n)                             rdata_q <= '0;
        else if (slot == SLOT_DATA && !wr_req) rdata_q <= rd_word;
    end
endmodule

// File: rtl/dpmem_shared.sv
// Module: top of the double-pumped shared memory. Time-multiplexes one
// single-ported word memory between instruction fetch (first fast cycle)
// and data read/write (second fast cycle) of each processor cycle.
// Assumes: inputs are held stable for both fast cycles of a processor cycle.
module dpmem_shared
    import dpmem_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int HALF_W     = 16,
    parameter int NUM_HALVES = 2
) (
    input  logic                         clk_fast,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            fetch_addr,
    input  logic [ADDR_W-1:0]            data_addr,
    input  logic                         data_we,
    input  logic [HALF_W*NUM_HALVES-1:0] data_wdata,
    output logic [HALF_W*NUM_HALVES-1:0] instr_out,
    output logic [HALF_W*NUM_HALVES-1:0] rdata_out,
    output logic                         slot_data
);
    localparam int WORD_W = HALF_W * NUM_HALVES;

    slot_e             slot;
    logic [ADDR_W-1:0] mem_addr;
    logic              bank_we;
    logic [WORD_W-1:0] rd_word;

    dpmem_slot_ctrl u_slot (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .slot     (slot)
    );

    // Route the fetch address in the instruction slot, the data address otherwise.
    always_comb mem_addr = (slot == SLOT_INSTR) ? fetch_addr : data_addr;

    // Allow writes only in the data slot and never during reset.
    always_comb bank_we = rst_n && (slot == SLOT_DATA) && data_we;

    // One bank per half; half 0 holds the lowest bits.
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_bank
        dpmem_bank #(
            .ADDR_W (ADDR_W),
            .DATA_W (HALF_W)
        ) u_bank (
            .clk_fast (clk_fast),
            .wr_en    (bank_we),
            .addr     (mem_addr),
            .wr_data  (data_wdata[h*HALF_W +: HALF_W]),
            .rd_data  (rd_word[h*HALF_W +: HALF_W])
        );
    end

    dpmem_capture #(
        .WORD_W (WORD_W)
    ) u_cap (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .slot     (slot),
        .wr_req   (data_we),
        .rd_word  (rd_word),
        .instr_q  (instr_out),
        .rdata_q  (rdata_out)
    );

    // Show which slot the coming fast edge serves.
    always_comb slot_data = (slot == SLOT_DATA);
endmodule

// File: rtl/dpmem_shared_chk.sv
// Module: assertion checker for dpmem_shared, attached by bind.
// Assumes: it observes only the top-level ports.
module dpmem_shared_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk_fast,
    input logic              rst_n,
    input logic              data_we,
    input logic [WORD_W-1:0] instr_out,
    input logic [WORD_W-1:0] rdata_out,
    input logic              slot_data
);
    // R1: reset clears both outputs and selects the instruction slot.
    p_reset_state_r1: assert property (@(posedge clk_fast)
        !rst_n |=> (instr_out == '0 && rdata_out == '0 && !slot_data));

    // R2: the slot alternates on every fast edge.
    p_slot_toggle_r2: assert property (@(posedge clk_fast) disable iff (!rst_n)
        1'b1 |=> (slot_data != $past(slot_data)));

    // R4: the instruction is held through the data slot.
    p_instr_hold_r4: assert property (@(posedge clk_fast) disable iff (!rst_n)
        slot_data |=> $stable(instr_out));

    // R5: read data does not move in the instruction slot.
    p_rdata_hold_r5: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !slot_data |=> $stable(rdata_out));

    // R6: a write slot leaves the read data as it was.
    p_write_keeps_r6: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (slot_data && data_we) |=> $stable(rdata_out));
endmodule

bind dpmem_shared dpmem_shared_chk #(
    .WORD_W (HALF_W * NUM_HALVES)
) u_chk (
    .clk_fast  (clk_fast),
    .rst_n     (rst_n),
    .data_we   (data_we),
    .instr_out (instr_out),
    .rdata_out (rdata_out),
    .slot_data (slot_data)
);

// File: tb/dpmem_shared_tb_top.sv
// Bench: random and directed processor cycles against a reference word array.
module dpmem_shared_tb_top;
    localparam int ADDR_W = 6;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk_fast = 1'b0;
    logic              rst_n    = 1'b0;
    logic [ADDR_W-1:0] fetch_addr = '0;
    logic [ADDR_W-1:0] data_addr  = '0;
    logic              data_we    = 1'b0;
    logic [31:0]       data_wdata = '0;
    logic [31:0]       instr_out;
    logic [31:0]       rdata_out;
    logic              slot_data;

    logic [31:0] ref_mem   [DEPTH];
    logic        ref_known [DEPTH];
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    dpmem_shared dut_i (
        .clk_fast   (clk_fast),
        .rst_n      (rst_n),
        .fetch_addr (fetch_addr),
        .data_addr  (data_addr),
        .data_we    (data_we),
        .data_wdata (data_wdata),
        .instr_out  (instr_out),
        .rdata_out  (rdata_out),
        .slot_data  (slot_data)
    );

    always #4 clk_fast = ~clk_fast;

    // Word pattern with distinct upper and lower halves per address.
    function automatic logic [31:0] pattern(input int a);
        return {16'hC000 ^ 16'(a * 37), 16'h0300 ^ 16'(a * 11 + 5)};
    endfunction

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // One processor cycle; with we_early the enable is high only in the instruction slot.
    task automatic cpu_cycle(input logic [ADDR_W-1:0] fa, input logic [ADDR_W-1:0] da,
                             input logic we, input logic [31:0] wd, input bit we_early);
        logic [31:0] prev_rd;
        logic [31:0] seen_instr;
        logic        old_known;
        logic [31:0] old_word;
        check32("R2", {31'b0, slot_data}, 32'd0);
        fetch_addr = fa;
        data_addr  = da;
        data_we    = we | we_early;
        data_wdata = wd;
        prev_rd    = rdata_out;
        old_known  = ref_known[fa];
        old_word   = ref_mem[fa];
        @(posedge clk_fast);
        @(negedge clk_fast);
        check32("R2", {31'b0, slot_data}, 32'd1);
        if (old_known) check32((we && fa == da) ? "R7" : "R3", instr_out, old_word);
        check32("R5", rdata_out, prev_rd);
        seen_instr = instr_out;
        if (we_early) data_we = 1'b0;
        @(posedge clk_fast);
        @(negedge clk_fast);
        check32("R4", instr_out, seen_instr);
        if (we && !we_early) begin
            ref_mem[da]   = wd;
            ref_known[da] = 1'b1;
            check32("R6", rdata_out, prev_rd);
        end else if (ref_known[da]) begin
            check32(we_early ? "R8" : "R5", rdata_out, ref_mem[da]);
        end
        data_we = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        for (int i = 0; i < DEPTH; i++) begin
            ref_known[i] = 1'b0;
            ref_mem[i]   = '0;
        end
        // R1: hold reset for several edges, then check the cleared state.
        repeat (5) @(posedge clk_fast);
        @(negedge clk_fast);
        check32("R1", instr_out, 32'd0);
        check32("R1", rdata_out, 32'd0);
        check32("R1", {31'b0, slot_data}, 32'd0);
        rst_n = 1'b1;

        // Fill every word with a known pattern.
        for (int i = 0; i < DEPTH; i++)
            cpu_cycle('0, ADDR_W'(i), 1'b1, pattern(i), 1'b0);

        // R9: halves rebuild at their own bit positions.
        cpu_cycle(ADDR_W'(3), ADDR_W'(9), 1'b1, 32'hA5A5_1234, 1'b0);
        cpu_cycle(ADDR_W'(9), ADDR_W'(9), 1'b0, 32'h0, 1'b0);
        check32("R9", {16'h0, rdata_out[31:16]}, 32'h0000_A5A5);
        check32("R9", {16'h0, rdata_out[15:0]},  32'h0000_1234);
        check32("R9", {16'h0, instr_out[31:16]}, 32'h0000_A5A5);

        // R7: fetch and write to the same address in one cycle.
        cpu_cycle(ADDR_W'(20), ADDR_W'(20), 1'b1, 32'hDEAD_BEEF, 1'b0);
        cpu_cycle(ADDR_W'(20), ADDR_W'(1), 1'b0, 32'h0, 1'b0);
        check32("R7", instr_out, 32'hDEAD_BEEF);

        // R8: enable high only during the instruction slot writes nothing.
        cpu_cycle(ADDR_W'(0), ADDR_W'(33), 1'b0, 32'h1111_2222, 1'b1);
        check32("R8", rdata_out, pattern(33));
        cpu_cycle(ADDR_W'(33), ADDR_W'(33), 1'b0, 32'h0, 1'b0);
        check32("R8", instr_out, pattern(33));

        // Constrained random cycles with frequent address overlap.
        for (int n = 0; n < 400; n++) begin
            logic [ADDR_W-1:0] fa;
            logic [ADDR_W-1:0] da;
            fa = ADDR_W'($urandom % DEPTH);
            da = ($urandom % 4 == 0) ? fa : ADDR_W'($urandom % DEPTH);
            cpu_cycle(fa, da, ($urandom % 3 == 0), $urandom, ($urandom % 16 == 0));
        end

        // R1: reset mid-run clears the outputs again but keeps memory.
        rst_n = 1'b0;
        repeat (3) @(posedge clk_fast);
        @(negedge clk_fast);
        check32("R1", instr_out, 32'd0);
        check32("R1", rdata_out, 32'd0);
        rst_n = 1'b1;
        cpu_cycle(ADDR_W'(20), ADDR_W'(9), 1'b0, 32'h0, 1'b0);
        check32("R1", rdata_out, ref_mem[9]);
        finish_run();
    end
endmodule